// File: doc/BRIEF.md
# Little-Endian Load/Store Lane Unit

This unit sits between the load/store datapath of a processor and a byte-addressable data memory whose port is one 32-bit word wide. For every access it adds a sign-extended 16-bit displacement to a base register value to form the effective byte address. It then registers a memory request for that address. A stored byte or halfword is placed on the byte lanes it occupies in little-endian order, and the unit raises the matching byte enables. A loaded byte or halfword is taken from the returned word and widened to 32 bits, with sign or zero extension.

A halfword at an odd address, or a word at an address that is not a multiple of four, is not sent to memory. The unit raises a misalignment flag for one cycle instead. A request is presented in one cycle. The memory request, byte enables and store data appear on the registered outputs after the next clock edge. The memory returns read data during that same output cycle, and the extracted load value is available combinationally from it.

Top module: `le_lane_unit`

## Requirements
- R1: One cycle after a request with `req_valid` high, `mem_addr` equals `req_base` plus `req_disp` sign-extended from 16 to 32 bits, modulo 2^32.
- R2: `req_size` selects the access size: 2'b00 is a byte, 2'b01 is a halfword, and 2'b10 is a word. The reserved code 2'b11 behaves exactly like a word.
- R3: For an aligned store, `mem_be` has four bits, and bit i enables the byte at address (effective address with bits [1:0] cleared) + i. A byte sets only bit addr[1:0]. A halfword sets bits addr[1:0] and addr[1:0]+1. A word sets all four bits. For loads and idle cycles, `mem_be` is zero.
- R4: Store data is little-endian. On the enabled lanes, the lane at the lowest address carries `req_wdata[7:0]` and each following lane carries the next byte up. For example, a word 0x004C4B40 stored at A puts 0x40 at A and 0x00 at A+3.
- R5: A halfword access with addr[0]=1, or a word access with addr[1:0]≠0, sets `misalign` in the output cycle. In that cycle `mem_req` and `mem_we` are 0 and `mem_be` is 0, so memory is left unchanged.
- R6: An aligned load raises `load_valid` and returns the addressed byte (lane addr[1:0]), halfword (lanes addr[1:0] and addr[1:0]+1) or whole word on `load_data`. Byte and halfword results are sign-extended when `req_zext` is 0.
- R7: With `req_zext` set, byte and halfword load results have zeros above bit 7 or bit 15.
- R8: A misaligned load gives `load_valid`=0 and `load_data`=0. `load_valid` is never high together with `mem_we`.
- R9: While `rst_n` is low at a clock edge, every registered output clears to zero.
- R10: A cycle with `req_valid` low produces `mem_req`, `mem_we`, `mem_be`, `misalign` and `load_valid` all zero in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code |
| req_zext | input | 1 | Zero-extend byte/halfword loads |
| req_base | input | 32 | Base register value |
| req_disp | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store data, right-justified |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Effective byte address |
| mem_be | output | 4 | Byte lane write enables |
| mem_wdata | output | 32 | Lane-steered store data |
| mem_rdata | input | 32 | Word returned by memory for `mem_addr` |
| misalign | output | 1 | Misaligned access flag |
| load_valid | output | 1 | Load result valid |
| load_data | output | 32 | Extracted and extended load value |

## Verification
The bench targets displacements at both ends of the signed range and bases near the 32-bit wrap. A design that zero-extended the displacement, or dropped the carry, would put the access in the wrong place. Halfword and byte accesses go to every lane offset, including the upper halfword. Lane steering done in big-endian order, or an enable mask that is not shifted, would corrupt the neighbouring bytes of memory, and later loads would read those bytes back wrong. Misaligned halfwords and words are mixed in with aligned traffic. A unit that still wrote memory on a misaligned access, or flagged an aligned one, fails either the strobe checks or the following readback. Negative bytes and halfwords are loaded under both extension settings, which exposes an extension that is inverted or applied at the wrong width.

// File: rtl/le_lane_pkg.sv
package le_lane_pkg;

   localparam int unsigned WORD_BYTES = 4;
   localparam int unsigned WORD_W     = WORD_BYTES * 8;

   typedef enum logic [1:0] {
      ACC_BYTE = 2'b00,
      ACC_HALF = 2'b01,
      ACC_WORD = 2'b10,
      ACC_WRSV = 2'b11
   } acc_size_e;

   // An access is legal when its low address bits fit its natural alignment.
   function automatic logic is_misaligned(acc_size_e sz, logic [1:0] lo);
      case (sz)
         ACC_BYTE: is_misaligned = 1'b0;
         ACC_HALF: is_misaligned = lo[0];
         default:  is_misaligned = (lo != 2'b00);
      endcase
   endfunction

endpackage

// File: rtl/le_lane_agen.sv
module le_lane_agen #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DISP_W = 16
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [DISP_W-1:0] disp,
   output logic [ADDR_W-1:0] ea
);

   logic [ADDR_W-1:0] disp_ext;

   initial begin : elab_chk
      assert (DISP_W >= 1 && DISP_W <= ADDR_W)
         else $error("le_lane_agen: DISP_W must be in 1..ADDR_W");
   end

   generate
      if (DISP_W < ADDR_W) begin : g_sext
         assign disp_ext = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
      end else begin : g_full
         assign disp_ext = disp;
      end
   endgenerate

   assign ea = base + disp_ext;

endmodule

// File: rtl/le_lane_steer.sv
module le_lane_steer import le_lane_pkg::*; #(
   parameter int unsigned NLANE = 4,
   parameter int unsigned OFF_W = 2
) (
   input  logic                 en,
   input  acc_size_e            size,
   input  logic [OFF_W-1:0]     off,
   input  logic [WORD_W-1:0]    wdata,
   output logic [NLANE-1:0]     be,
   output logic [NLANE*8-1:0]   lane_data
);

   initial begin : elab_chk
      assert (NLANE >= WORD_BYTES && (1 << OFF_W) == NLANE)
         else $error("le_lane_steer: NLANE must be a power of two >= 4");
   end

   generate
      for (genvar i = 0; i < NLANE; i++) begin : g_lane
         localparam logic [OFF_W-1:0] IDX = OFF_W'(i);
         localparam int unsigned HSEL = i % 2;
         localparam int unsigned WSEL = i % WORD_BYTES;
         logic hit;

         // Lane i lies inside the access when the offsets match at its granule.
         always_comb begin
            case (size)
               ACC_BYTE: hit = (off == IDX);
               ACC_HALF: hit = ((off >> 1) == (IDX >> 1));
               default:  hit = ((off >> 2) == (IDX >> 2));
            endcase
         end

         // Replicate the datum so each lane already holds its own byte.
         always_comb begin
            case (size)
               ACC_BYTE: lane_data[8*i +: 8] = wdata[7:0];
               ACC_HALF: lane_data[8*i +: 8] = wdata[8*HSEL +: 8];
               default:  lane_data[8*i +: 8] = wdata[8*WSEL +: 8];
            endcase
         end

         assign be[i] = en & hit;
      end
   endgenerate

endmodule

// File: rtl/le_lane_extract.sv
module le_lane_extract import le_lane_pkg::*; #(
   parameter int unsigned NLANE = 4,
   parameter int unsigned OFF_W = 2
) (
   input  logic [NLANE*8-1:0] rdata,
   input  logic [OFF_W-1:0]   off,
   input  acc_size_e          size,
   input  logic               zext,
   output logic [WORD_W-1:0]  data
);

   logic [NLANE*8-1:0] shifted;
   logic               fill_b;
   logic               fill_h;

   // Lowest-addressed byte of the access moves to bit 0.
   assign shifted = rdata >> {off, 3'b000};
   assign fill_b  = ~zext & shifted[7];
   assign fill_h  = ~zext & shifted[15];

   always_comb begin
      case (size)
         ACC_BYTE: data = {{(WORD_W-8){fill_b}}, shifted[7:0]};
         ACC_HALF: data = {{(WORD_W-16){fill_h}}, shifted[15:0]};
         default:  data = shifted[WORD_W-1:0];
      endcase
   end

endmodule

// File: rtl/le_lane_unit.sv
module le_lane_unit import le_lane_pkg::*; #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DISP_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [1:0]          req_size,
   input  logic                req_zext,
   input  logic [ADDR_W-1:0]   req_base,
   input  logic [DISP_W-1:0]   req_disp,
   input  logic [31:0]         req_wdata,
   output logic                mem_req,
   output logic                mem_we,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [DATA_W/8-1:0] mem_be,
   output logic [DATA_W-1:0]   mem_wdata,
   input  logic [DATA_W-1:0]   mem_rdata,
   output logic                misalign,
   output logic                load_valid,
   output logic [31:0]         load_data
);

   localparam int unsigned NLANE = DATA_W / 8;
   localparam int unsigned OFF_W = $clog2(NLANE);

   initial begin : elab_chk
      assert (DATA_W % 8 == 0 && DATA_W >= WORD_W)
         else $error("le_lane_unit: DATA_W must be a byte multiple >= 32");
      assert (ADDR_W >= OFF_W + 1)
         else $error("le_lane_unit: ADDR_W too small for lane offset");
   end

   acc_size_e          sz;
   logic [ADDR_W-1:0]  ea;
   logic               mis;
   logic               acc_ok;
   logic [NLANE-1:0]   be_c;
   logic [DATA_W-1:0]  lane_c;
   logic [WORD_W-1:0]  ext_c;

   acc_size_e          size_q;
   logic [OFF_W-1:0]   off_q;
   logic               zext_q;

   assign sz     = acc_size_e'(req_size);
   assign mis    = is_misaligned(sz, ea[1:0]);
   assign acc_ok = req_valid & ~mis;

   le_lane_agen #(
      .ADDR_W (ADDR_W),
      .DISP_W (DISP_W)
   ) u_agen (
      .base (req_base),
      .disp (req_disp),
      .ea   (ea)
   );

   le_lane_steer #(
      .NLANE (NLANE),
      .OFF_W (OFF_W)
   ) u_steer (
      .en        (acc_ok & req_write),
      .size      (sz),
      .off       (ea[OFF_W-1:0]),
      .wdata     (req_wdata),
      .be        (be_c),
      .lane_data (lane_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_req    <= 1'b0;
         mem_we     <= 1'b0;
         mem_addr   <= '0;
         mem_be     <= '0;
         mem_wdata  <= '0;
         misalign   <= 1'b0;
         load_valid <= 1'b0;
         size_q     <= ACC_BYTE;
         off_q      <= '0;
         zext_q     <= 1'b0;
      end else begin
         mem_req    <= acc_ok;
         mem_we     <= acc_ok & req_write;
         mem_be     <= be_c;
         misalign   <= req_valid & mis;
         load_valid <= acc_ok & ~req_write;
         if (req_valid) begin
            mem_addr  <= ea;
            mem_wdata <= lane_c;
            size_q    <= sz;
            off_q     <= ea[OFF_W-1:0];
            zext_q    <= req_zext;
         end
      end
   end

   le_lane_extract #(
      .NLANE (NLANE),
      .OFF_W (OFF_W)
   ) u_extract (
      .rdata (mem_rdata),
      .off   (off_q),
      .size  (size_q),
      .zext  (zext_q),
      .data  (ext_c)
   );

   assign load_data = load_valid ? ext_c : '0;

   AST_MISALIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      misalign |-> (!mem_req && !mem_we && mem_be == '0)); // R5

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(req_valid) |-> (!mem_req && !mem_we && mem_be == '0 && !misalign && !load_valid)); // R10

   AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == 4)); // R3

   AST_WORD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && (size_q == ACC_WORD || size_q == ACC_WRSV)) |-> ($countones(mem_be) == 4)); // R2

   AST_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      load_valid |-> (mem_req && !mem_we && !misalign)); // R8

   AST_ZEXT_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      (load_valid && zext_q && size_q == ACC_BYTE) |-> (load_data[31:8] == '0)); // R7

endmodule

// File: tb/le_lane_unit_bench.sv
module le_lane_unit_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_write, req_zext;
   logic [1:0]  req_size;
   logic [31:0] req_base, req_wdata;
   logic [15:0] req_disp;
   logic        mem_req, mem_we, misalign, load_valid;
   logic [31:0] mem_addr, mem_wdata, mem_rdata, load_data;
   logic [3:0]  mem_be;

   int n_chk = 0;
   int n_fail = 0;

   logic [31:0] mem_words [16];
   logic [7:0]  refm [64];

   always #(CLK_PERIOD/2) clk = ~clk;

   le_lane_unit u_le_lane_unit (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_write (req_write), .req_size (req_size),
      .req_zext (req_zext), .req_base (req_base), .req_disp (req_disp),
      .req_wdata (req_wdata),
      .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr),
      .mem_be (mem_be), .mem_wdata (mem_wdata), .mem_rdata (mem_rdata),
      .misalign (misalign), .load_valid (load_valid), .load_data (load_data)
   );

   assign mem_rdata = mem_words[mem_addr[5:2]];

   always @(posedge clk) begin
      if (mem_we) begin
         for (int i = 0; i < 4; i++)
            if (mem_be[i]) mem_words[mem_addr[5:2]][8*i +: 8] <= mem_wdata[8*i +: 8];
      end
   end

   function automatic int nbytes(logic [1:0] s);
      return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
   endfunction

   function automatic logic exp_mis(logic [31:0] ea, logic [1:0] s);
      if (s == 2'b00) return 1'b0;
      if (s == 2'b01) return ea[0];
      return ea[1:0] != 2'b00;
   endfunction

   function automatic logic [3:0] exp_be(logic [31:0] ea, logic [1:0] s);
      logic [3:0] m;
      m = (nbytes(s) == 1) ? 4'b0001 : (nbytes(s) == 2) ? 4'b0011 : 4'b1111;
      return m << ea[1:0];
   endfunction

   function automatic logic [31:0] exp_load(logic [31:0] ea, logic [1:0] s, logic z);
      logic [31:0] v;
      logic [5:0]  a;
      v = '0;
      for (int k = 0; k < nbytes(s); k++) begin
         a = ea[5:0] + 6'(k);
         v[8*k +: 8] = refm[a];
      end
      if (!z && nbytes(s) == 1 && v[7])  v[31:8]  = '1;
      if (!z && nbytes(s) == 2 && v[15]) v[31:16] = '1;
      return v;
   endfunction

   task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   task automatic do_op(input logic wr, input logic [1:0] s, input logic z,
                        input logic [31:0] b, input logic [15:0] d, input logic [31:0] wd);
      logic [31:0] ea, ld_exp;
      logic        mis;
      logic [3:0]  be_exp;
      logic [5:0]  a;
      ea     = b + {{16{d[15]}}, d};
      mis    = exp_mis(ea, s);
      be_exp = (wr && !mis) ? exp_be(ea, s) : 4'b0000;
      ld_exp = exp_load(ea, s, z);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_size = s; req_zext = z;
      req_base = b; req_disp = d; req_wdata = wd;
      if (wr && !mis) begin
         for (int k = 0; k < nbytes(s); k++) begin
            a = ea[5:0] + 6'(k);
            refm[a] = wd[8*k +: 8];
         end
      end
      @(posedge clk); #1;
      chk(mem_addr == ea, "R1 effective address", mem_addr, ea);
      chk(misalign == mis, "R5 misalign flag", 32'(misalign), 32'(mis));
      chk(mem_req == !mis, "R5 mem_req", 32'(mem_req), 32'(!mis));
      chk(mem_we == (wr && !mis), "R5 mem_we", 32'(mem_we), 32'(wr && !mis));
      chk(mem_be == be_exp, "R3 R2 byte enables", 32'(mem_be), 32'(be_exp));
      if (wr && !mis) begin
         for (int k = 0; k < nbytes(s); k++) begin
            chk(mem_wdata[8*(ea[1:0]+2'(k)) +: 8] == wd[8*k +: 8], "R4 lane data",
                32'(mem_wdata[8*(ea[1:0]+2'(k)) +: 8]), 32'(wd[8*k +: 8]));
         end
      end
      if (!wr && !mis) begin
         chk(load_valid == 1'b1, "R6 load_valid", 32'(load_valid), 32'd1);
         chk(load_data == ld_exp, z ? "R7 zext load" : "R6 load data", load_data, ld_exp);
      end else begin
         chk(load_valid == 1'b0, "R8 no load_valid", 32'(load_valid), 32'd0);
         chk(load_data == '0, "R8 load_data zero", load_data, 32'd0);
      end
   endtask

   task automatic do_idle();
      @(negedge clk);
      req_valid = 1'b0;
      @(posedge clk); #1;
      chk(!mem_req && !mem_we && mem_be == 4'b0 && !misalign && !load_valid,
          "R10 idle quiet", {mem_req, mem_we, misalign, load_valid, 24'b0, mem_be}, 32'd0);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      summary();
      $finish;
   end

   initial begin : stim
      logic [31:0] b, w;
      logic [15:0] d;
      void'($urandom(32'h1A2B3C4D));
      for (int i = 0; i < 16; i++) begin
         w = $urandom;
         mem_words[i] = w;
         for (int k = 0; k < 4; k++) refm[4*i+k] = w[8*k +: 8];
      end
      rst_n = 1'b0; req_valid = 1'b1; req_write = 1'b1; req_size = 2'b10;
      req_zext = 1'b0; req_base = 32'h0; req_disp = 16'h0; req_wdata = 32'hFFFF_FFFF;
      repeat (3) @(posedge clk);
      #1;
      chk(!mem_req && !mem_we && mem_be == 4'b0 && !misalign && !load_valid && mem_addr == '0
          && mem_wdata == '0, "R9 reset state", mem_addr, 32'd0);
      @(negedge clk);
      req_valid = 1'b0;
      rst_n = 1'b1;
      do_idle();

      // Directed corner cases
      do_op(1'b1, 2'b10, 1'b0, 32'h0000_0020, 16'h0000, 32'h004C_4B40);
      do_op(1'b0, 2'b00, 1'b1, 32'h0000_0020, 16'h0000, 32'h0);
      do_op(1'b0, 2'b00, 1'b1, 32'h0000_0023, 16'h0000, 32'h0);
      do_op(1'b0, 2'b01, 1'b0, 32'h0000_0022, 16'h0000, 32'h0);
      do_op(1'b1, 2'b00, 1'b0, 32'h0000_0021, 16'h0000, 32'h0000_0080);
      do_op(1'b0, 2'b00, 1'b0, 32'h0000_0021, 16'h0000, 32'h0);
      do_op(1'b0, 2'b00, 1'b1, 32'h0000_0021, 16'h0000, 32'h0);
      do_op(1'b1, 2'b01, 1'b0, 32'h0000_0030, 16'hFFF6, 32'h0000_F00D);
      do_op(1'b0, 2'b01, 1'b0, 32'h0000_0026, 16'h0000, 32'h0);
      do_op(1'b0, 2'b01, 1'b1, 32'h0000_0026, 16'h0000, 32'h0);
      do_op(1'b1, 2'b01, 1'b0, 32'h0000_0021, 16'h0000, 32'hDEAD_BEEF);
      do_op(1'b1, 2'b10, 1'b0, 32'h0000_0020, 16'h0002, 32'hDEAD_BEEF);
      do_op(1'b1, 2'b11, 1'b0, 32'h0000_0021, 16'h0000, 32'hDEAD_BEEF);
      do_op(1'b0, 2'b10, 1'b0, 32'h0000_0020, 16'h0000, 32'h0);
      do_op(1'b0, 2'b11, 1'b0, 32'h0000_0030, 16'hFFF0, 32'h0);
      do_op(1'b0, 2'b10, 1'b0, 32'h0000_0001, 16'h7FFF, 32'h0);
      do_op(1'b0, 2'b10, 1'b0, 32'h0000_8000, 16'h8000, 32'h0);
      do_op(1'b1, 2'b10, 1'b0, 32'hFFFF_FFFC, 16'h0008, 32'h1234_5678);
      do_op(1'b0, 2'b00, 1'b0, 32'h0000_0007, 16'h0000, 32'h0);
      do_idle();

      // Random traffic
      for (int n = 0; n < 600; n++) begin
         b = $urandom;
         d = 16'($urandom);
         if (n % 7 == 0) d = (n % 2 == 0) ? 16'h8000 : 16'h7FFF;
         if (n % 3 != 0) b[1:0] = 2'b00;
         if (n % 2 == 0) d[1:0] = 2'b00;
         do_op(1'($urandom), 2'($urandom), 1'($urandom), b, d, $urandom);
         if (n % 50 == 0) do_idle();
      end

      // Final readback of the whole memory as words
      for (int i = 0; i < 16; i++) do_op(1'b0, 2'b10, 1'b0, 32'(4*i), 16'h0, 32'h0);
      do_idle();
      summary();
      $finish;
   end

endmodule